// File: doc/BRIEF.md
# Cartridge Save-Memory Controller with Type Autodetect

This block watches a 24-bit byte-addressed bus and owns the battery-backed save area of a cartridge. Behind that area sits either a parallel byte-wide SRAM or a serial EEPROM whose clock and data lines are driven by software toggling bits. The controller does not know in advance which kind is present. It works out the type from the first access that lands in the save window and keeps that answer until reset.

A small control register at a fixed bus address carries an enable bit and a write-protect bit. In SRAM mode, byte writes go into an internal byte array and reads come back from it. A sticky flag records whether any stored byte ever changed value.

In EEPROM mode the window shrinks to two bytes. Reads return the EEPROM's output byte. Writes feed a pending/commit pair for the data and clock lines. A pending level is only pushed onto the lines when enough cycles have passed since the last real line change, so that quick bursts of bus writes settle before they reach the device.

Top module: `save_mem_ctrl`

## Requirements
- R1: A byte write to address 0xA130F1 loads bus_wdata bit 0 into the enable bit and bit 1 into the write-protect bit. It leaves the detected type, the committed line levels and the SRAM contents untouched.
- R2: A read inside the window sets rd_hit only when the enable bit is set or EEPROM mode has been detected. Otherwise rd_hit is 0 and rd_data is 0.
- R3: While the type is undetected, a write to WIN_BASE or WIN_BASE+1 selects EEPROM mode. After that the window covers only those two bytes, and reads elsewhere in the former window do not hit.
- R4: While the type is undetected, a write to any other window address selects SRAM mode and stores the byte.
- R5: While the type is undetected and enable is set, a read of a window address above WIN_BASE+1 selects SRAM mode, so a later write to WIN_BASE is stored as SRAM data.
- R6: In SRAM mode a byte write stores into offset (address − WIN_BASE) unless write-protect is set, in which case the store is dropped. A byte read returns {8'h00, byte}. A word read (bus_word=1) returns the even-address byte in bits 15:8 and the odd-address byte in bits 7:0.
- R7: sram_dirty rises only on a stored write whose value differs from the byte already held (contents are 0 after reset) and then stays 1 until reset.
- R8: In EEPROM mode a word read returns {ee_rdata, ee_rdata} and a byte read returns {8'h00, ee_rdata}.
- R9: In EEPROM mode, a write whose cycle count minus the last line-change timestamp (unsigned, CNT_W bits) is below MIN_GAP only replaces the pending levels (bus_wdata bit 0 = data, bit 1 = clock). The lines stay as they are.
- R10: Otherwise the pending levels are driven onto ee_sda/ee_scl first and then the new levels become pending. The timestamp takes the current count only when that commit changed a line.
- R11: The detected type never changes except through reset.
- R12: After reset: type undetected, enable and write-protect 0, sram_dirty 0, ee_sda and ee_scl 1, pending levels 1, cycle count and timestamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = byte write, 0 = read |
| bus_word | input | 1 | Read width: 1 = 16-bit, 0 = byte |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write byte |
| ee_rdata | input | 8 | Output byte of the serial EEPROM |
| rd_hit | output | 1 | Read claimed by the save window |
| rd_data | output | 16 | Read data (0 when not hit) |
| ee_sda | output | 1 | Committed EEPROM data line level |
| ee_scl | output | 1 | Committed EEPROM clock line level |
| sram_dirty | output | 1 | A stored SRAM byte has changed value |

## Verification
Type detection and the action the same access performs fall on one clock edge. The first write to WIN_BASE must both flip the block into EEPROM mode and enter the line pacer, and the first write elsewhere must both pick SRAM and store its byte. The bench provokes each case from a fresh reset. It judges them by reading back the stored byte, or by comparing the lines against an arithmetic model of pending, commit and timestamp, which it steps through a sweep of write gaps that straddle MIN_GAP.

// File: rtl/save_mem_pkg.sv
// Shared types for the save-memory controller.
package save_mem_pkg;

    // Control and detection state kept by the register block.
    typedef struct packed {
        logic detected;   // memory type has been decided
        logic ee_mode;    // 1 = serial EEPROM, 0 = parallel SRAM
        logic wprot;      // SRAM write-protect
        logic enable;     // window enable for reads
    } save_ctrl_t;

    // Fixed bus address of the control byte.
    localparam logic [23:0] CTRL_ADDR = 24'hA130F1;

endpackage

// File: rtl/save_ctrl_regs.sv
// Control register and memory-type detector.
// Holds enable/write-protect (loaded only by control writes) and the
// sticky detected/mode pair (set once by detection pulses, cleared by
// reset only). Assumes det_ee and det_sram are never both high.
module save_ctrl_regs
    import save_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_bits,
    input  logic       det_ee,
    input  logic       det_sram,
    output save_ctrl_t ctrl
);

    // Register update: control bits on control writes, type on first detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.enable <= ctrl_bits[0];
                ctrl.wprot  <= ctrl_bits[1];
            end
            if (!ctrl.detected && det_ee) begin
                ctrl.detected <= 1'b1;
                ctrl.ee_mode  <= 1'b1;
            end else if (!ctrl.detected && det_sram) begin
                ctrl.detected <= 1'b1;
            end
        end
    end

    // R1: a control write loads exactly the two low bits and keeps the mode.
    p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !det_ee && !det_sram |=>
            ctrl.enable == $past(ctrl_bits[0]) && ctrl.wprot == $past(ctrl_bits[1])
            && ctrl.ee_mode == $past(ctrl.ee_mode));

    // R11: once decided, the type holds until reset.
    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.detected |=> ctrl.detected && $stable(ctrl.ee_mode));

endmodule

// File: rtl/save_sram_array.sv
// Byte-wide SRAM image with change tracking.
// Stores one byte per write enable, serves byte and big-endian word reads,
// and raises a sticky dirty flag when a store alters a byte.
// Assumes DEPTH is a power of two of at least 2; contents clear on reset.
module save_sram_array #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    input  logic          rd_word,
    output logic [15:0]   rdata,
    output logic          dirty
);

    logic [7:0] mem [DEPTH];

    // Array store and dirty tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            dirty <= 1'b0;
        end else if (we) begin
            mem[waddr] <= wdata;
            if (mem[waddr] != wdata) dirty <= 1'b1;
        end
    end

    logic [AW-1:0] even_a, odd_a;
    assign even_a = {raddr[AW-1:1], 1'b0};
    assign odd_a  = {raddr[AW-1:1], 1'b1};

    // Read mux: word reads put the even byte on top.
    always_comb begin
        if (rd_word) rdata = {mem[even_a], mem[odd_a]};
        else         rdata = {8'h00, mem[raddr]};
    end

    // R6: a store is visible at its address on the next cycle.
    p_store_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

    // R7: the dirty flag never falls outside reset.
    p_dirty_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |=> dirty);

endmodule

// File: rtl/save_line_pacer.sv
// Rate limiter for bit-banged EEPROM line writes.
// Keeps a pending and a committed level pair (bit 0 data, bit 1 clock),
// a free-running cycle count and the time of the last real line change.
// A write inside the quiet gap only replaces the pending pair.
module save_line_pacer #(
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wbits,
    output logic       sda,
    output logic       scl
);

    localparam logic [CNT_W-1:0] GAP_L = CNT_W'(MIN_GAP);

    logic [CNT_W-1:0] cyc, last_ts, gap;
    logic [1:0]       pend, com;
    logic             quiet;

    assign gap   = cyc - last_ts;
    assign quiet = gap < GAP_L;

    // Free-running timestamp source.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    // Pending/commit handling of line writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 2'b11;
            com     <= 2'b11;
            last_ts <= '0;
        end else if (we) begin
            if (!quiet && pend != com) begin
                com     <= pend;
                last_ts <= cyc;
            end
            pend <= wbits;
        end
    end

    assign sda = com[0];
    assign scl = com[1];

    // R9: writes inside the quiet gap leave the lines alone.
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && quiet |=> $stable(com));

    // R10: the timestamp only moves together with a line change.
    p_ts_with_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_ts) |-> !$stable(com));

    // R10: a line change only ever comes from a write.
    p_change_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(com));

endmodule

// File: rtl/save_mem_ctrl.sv
// Cartridge save-memory controller, top level.
// Decodes the control byte and the save window, infers the memory type
// from the first qualifying access and routes it to the SRAM image or
// the EEPROM line pacer. Assumes WIN_BASE is aligned to SRAM_DEPTH and
// that the window does not cover the control address.
module save_mem_ctrl
    import save_mem_pkg::*;
#(
    parameter logic [23:0] WIN_BASE   = 24'h200000,
    parameter int          SRAM_DEPTH = 256,
    parameter int          CNT_W      = 16,
    parameter int          MIN_GAP    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic        bus_word,
    input  logic [23:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  ee_rdata,
    output logic        rd_hit,
    output logic [15:0] rd_data,
    output logic        ee_sda,
    output logic        ee_scl,
    output logic        sram_dirty
);

    localparam int          AW      = $clog2(SRAM_DEPTH);
    localparam logic [23:0] WIN_END = WIN_BASE + 24'(SRAM_DEPTH) - 24'd1;
    localparam logic [23:0] EE_TOP  = WIN_BASE + 24'd1;

    save_ctrl_t ctrl;
    logic wr, rd, ctrl_wr, in_full, ee_pair, in_win;
    logic det_ee, det_sram, ee_now, sram_we, ee_we;
    logic [15:0] sram_rdata;

    // Access classification and window decode.
    always_comb begin
        wr      = bus_valid && bus_write;
        rd      = bus_valid && !bus_write;
        ctrl_wr = wr && (bus_addr == CTRL_ADDR);
        in_full = (bus_addr >= WIN_BASE) && (bus_addr <= WIN_END);
        ee_pair = (bus_addr[23:1] == WIN_BASE[23:1]);
        in_win  = ctrl.ee_mode ? ee_pair : in_full;
    end

    // Type inference from the first write, or a high read while enabled.
    always_comb begin
        det_ee   = wr && !ctrl.detected && ee_pair;
        det_sram = !ctrl.detected &&
                   ((wr && in_full && !ee_pair) ||
                    (rd && ctrl.enable && in_full && (bus_addr > EE_TOP)));
        ee_now   = ctrl.ee_mode || det_ee;
        sram_we  = wr && in_full && !ee_now && !ctrl.wprot;
        ee_we    = wr && ee_now && ee_pair;
    end

    save_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (bus_wdata[1:0]),
        .det_ee    (det_ee),
        .det_sram  (det_sram),
        .ctrl      (ctrl)
    );

    save_sram_array #(.DEPTH(SRAM_DEPTH)) u_sram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sram_we),
        .waddr   (bus_addr[AW-1:0]),
        .wdata   (bus_wdata),
        .raddr   (bus_addr[AW-1:0]),
        .rd_word (bus_word),
        .rdata   (sram_rdata),
        .dirty   (sram_dirty)
    );

    save_line_pacer #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ee_we),
        .wbits (bus_wdata[1:0]),
        .sda   (ee_sda),
        .scl   (ee_scl)
    );

    // Read response: gated by enable or EEPROM mode.
    always_comb begin
        rd_hit  = rd && in_win && (ctrl.enable || ctrl.ee_mode);
        rd_data = 16'h0000;
        if (rd_hit) begin
            if (ctrl.ee_mode) rd_data = bus_word ? {ee_rdata, ee_rdata} : {8'h00, ee_rdata};
            else              rd_data = sram_rdata;
        end
    end

    // R2: no read is claimed while disabled and not in EEPROM mode.
    p_hit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (ctrl.enable || ctrl.ee_mode));

    // R3: in EEPROM mode only the two-byte window answers.
    p_ee_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && ctrl.ee_mode |-> bus_addr[23:1] == WIN_BASE[23:1]);

    // R6: protected SRAM never sees a store.
    p_wprot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.wprot |-> !sram_we);

endmodule

// File: tb/save_mem_ctrl_test.sv
module save_mem_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam logic [23:0] BASE = 24'h200000;
    localparam logic [23:0] CTRL = 24'hA130F1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 0, bus_write = 0, bus_word = 0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, ee_rdata = 8'h5A;
    logic rd_hit, ee_sda, ee_scl, sram_dirty;
    logic [15:0] rd_data;

    int total = 0, bad = 0, bcyc = 0;
    bit done = 0;
    logic [7:0] exp_mem [DEPTH];
    int m_last, m_pend, m_com;

    always #(CLK_PERIOD/2) clk = ~clk;

    save_mem_ctrl #(.WIN_BASE(BASE), .SRAM_DEPTH(DEPTH), .CNT_W(16), .MIN_GAP(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ee_rdata(ee_rdata), .rd_hit(rd_hit), .rd_data(rd_data),
        .ee_sda(ee_sda), .ee_scl(ee_scl), .sram_dirty(sram_dirty)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        bcyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        bcyc = 0; m_last = 0; m_pend = 3; m_com = 3;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
    endtask

    task automatic do_wr(input logic [23:0] a, input logic [7:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 0; bus_write = 0;
    endtask

    // Pacer model step for an EEPROM-mode write at the current bench cycle.
    task automatic ee_wr(input logic [23:0] a, input logic [7:0] d);
        if (((bcyc - m_last) & 16'hFFFF) < 16) m_pend = d[1:0];
        else begin
            if (m_pend != m_com) begin m_com = m_pend; m_last = bcyc; end
            m_pend = d[1:0];
        end
        do_wr(a, d);
    endtask

    task automatic do_rd(input logic [23:0] a, input logic w,
                         output logic hit, output logic [15:0] d);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_word = w;
        #1;
        hit = rd_hit; d = rd_data;
        tick();
        bus_valid = 0; bus_word = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic h;
        logic [15:0] d;

        // ---- Phase A: SRAM by read detection ----
        do_reset();
        check("R12 dirty", {15'b0, sram_dirty}, 16'h0);
        check("R12 lines", {14'b0, ee_scl, ee_sda}, 16'h3);
        do_rd(BASE + 4, 1'b0, h, d);
        check("R2 disabled no hit", {h, d[14:0]}, 16'h0);
        do_wr(CTRL, 8'hFD);                     // enable=1, wp=0
        do_rd(BASE + 4, 1'b0, h, d);            // R5 marks SRAM
        check("R2 enabled hit", {15'b0, h}, 16'h1);
        do_wr(BASE, 8'h00);                     // same value: no dirty
        check("R7 equal store keeps clean", {15'b0, sram_dirty}, 16'h0);
        check("R5 lines untouched", {14'b0, ee_scl, ee_sda}, 16'h3);
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
            do_wr(BASE + 24'(i), exp_mem[i]);
        end
        check("R7 dirty set", {15'b0, sram_dirty}, 16'h1);
        for (int i = 0; i < DEPTH; i++) begin
            do_rd(BASE + 24'(i), 1'b0, h, d);
            check("R6 byte read", d, {8'h00, exp_mem[i]});
        end
        for (int i = 0; i < DEPTH; i += 2) begin
            do_rd(BASE + 24'(i + 1), 1'b1, h, d);
            check("R6 word read", d, {exp_mem[i], exp_mem[i + 1]});
        end
        do_rd(BASE + DEPTH, 1'b0, h, d);
        check("R2 outside window", {15'b0, h}, 16'h0);
        do_wr(CTRL, 8'h03);                     // wp on
        do_wr(BASE + 2, 8'hAA);
        do_rd(BASE + 2, 1'b0, h, d);
        check("R6 wprot drop", d, {8'h00, exp_mem[2]});
        do_wr(CTRL, 8'h01);                     // wp off, mode kept
        do_wr(BASE, 8'h55);
        exp_mem[0] = 8'h55;
        do_rd(BASE, 1'b0, h, d);
        check("R11 stays SRAM", d, 16'h0055);
        check("R1 lines kept", {14'b0, ee_scl, ee_sda}, 16'h3);

        // ---- Phase C: SRAM by write detection ----
        do_reset();
        do_wr(BASE + 3, 8'h42);                 // enable still 0
        check("R7 dirty on first store", {15'b0, sram_dirty}, 16'h1);
        do_wr(BASE, 8'h11);
        do_wr(CTRL, 8'h01);
        ee_rdata = 8'h99;
        do_rd(BASE + 3, 1'b0, h, d);
        check("R4 write picks SRAM", d, 16'h0042);
        do_rd(BASE, 1'b1, h, d);
        check("R4 base stored as SRAM", d, 16'h1100);
        check("R4 lines idle", {14'b0, ee_scl, ee_sda}, 16'h3);

        // ---- Phase B: EEPROM detection and pacing ----
        do_reset();
        ee_rdata = 8'h5A;
        ee_wr(BASE, 8'h02);                     // detection write, quiet gap
        check("R9 first write pending only", {14'b0, ee_scl, ee_sda}, 16'h3);
        do_rd(BASE, 1'b1, h, d);
        check("R8 word dup", d, 16'h5A5A);
        check("R3 hit while disabled", {15'b0, h}, 16'h1);
        ee_rdata = 8'hC3;
        do_rd(BASE + 1, 1'b0, h, d);
        check("R8 byte read", d, 16'h00C3);
        do_rd(BASE + 2, 1'b0, h, d);
        check("R3 window shrunk", {15'b0, h}, 16'h0);
        do_wr(CTRL, 8'h01);
        check("R1 lines kept in EEPROM", {14'b0, ee_scl, ee_sda}, 16'({m_com[1], m_com[0]}));
        for (int k = 0; k < 60; k++) begin
            int g;
            g = (k * 7) % 23;
            for (int j = 0; j < g; j++) tick();
            ee_wr(BASE + 24'(k & 1), 8'((k * 3 + k / 5) & 3));
            check((g < 15) ? "R9 pacing" : "R10 pacing",
                  {14'b0, ee_scl, ee_sda}, 16'(m_com & 3));
        end
        do_rd(BASE + 6, 1'b0, h, d);
        check("R11 EEPROM kept", {15'b0, h}, 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule